// File: doc/BRIEF.md
# SPI NOR Flash Cycle Engine

This block runs one complete SPI NOR flash transaction for each request, picked from a small set of abstract cycle types. Software does not handle raw SPI opcodes. It writes a 24-bit flash address and, for program cycles, fills a 64-byte data buffer. It then writes the control/status word with a cycle code, a byte count minus one and the go bit. The engine then builds the whole serial sequence:

- an optional write-enable frame,
- the opcode,
- the address,
- a dummy byte,
- the data.

It drives this sequence over a single-lane mode-0 SPI master. When the cycle ends, the engine reports it through sticky flags that are cleared by writing 1.

Requests that cannot be run safely are refused before any pin moves. A request is refused if its cycle code is undefined, its address lies above a configurable limit, or it is a page program whose bytes would cross a 256-byte page. For read-type cycles, the engine places the returned bytes in the buffer from index 0 for software to drain. SCK runs at the system clock divided by twice a parameter.

Top module: `flash_cycle_engine`

## Requirements
- R1: After reset the address word and the control/status word read as zero, CS_n is high and SCK is low.
- R2: Register words are selected by a 5-bit word index.
  - Word 0 holds the address in bits 23:0.
  - Word 1 holds the count-minus-one in bits 29:24, the cycle code in bits 20:17, go in bit 16 (reads 0), in-progress in bit 5, and the flags in bits 2:0 (done 0, cycle error 1, access error 2).
  - Words 16 to 31 map the 64-byte buffer, with byte 4k+j of the buffer in bits 8j+7:8j of word 16+k.
- R3: Each cycle code sends its own opcode as the first byte of its command frame:
  - 0 read: 0x0B
  - 2 page program: 0x02
  - 3 4 KiB erase: 0x20
  - 4 64 KiB erase: 0xD8
  - 5 read SFDP: 0x5A
  - 6 read ID: 0x9F
  - 7 write status: 0x01
  - 8 read status: 0x05
- R4: Codes 2, 3, 4 and 7 are preceded by a separate one-byte 0x06 frame, with CS_n high between the two frames. The other codes send a single frame.
- R5: The address goes out as three bytes, most significant byte first. This applies to codes 0, 2, 3, 4 and 5. Codes 0 and 5 then add one dummy byte. Codes 3 and 4 have no data phase.
- R6: Read-type codes (0, 5, 6, 8) shift in count+1 bytes and store them in buffer bytes 0 to count.
- R7: Codes 2 and 7 send count+1 bytes taken from buffer bytes 0 to count.
- R8: A successful cycle sets the done flag. The in-progress bit reads 1 from the write that starts the cycle until the cycle ends.
- R9: A go with an undefined cycle code (1 or 9 to 15), or with an address above ADDR_MAX, sets the access-error flag and produces no SPI frame.
- R10: A page-program go whose low address byte plus count exceeds 255 sets the cycle-error flag and produces no SPI frame.
- R11: Writing word 1 clears each flag whose bit is written as 1 and leaves the others unchanged.
- R12: While in-progress is set, writes to word 1 fields, to the address word and to the buffer are ignored, and so is go.
- R13: SPI runs in mode 0. SCK idles low, MOSI changes after falling edges, and MISO is sampled on rising edges, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| sck_o | output | 1 | SPI clock |
| csn_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI serial data out |
| miso_i | input | 1 | SPI serial data in |

## Verification
The hardest condition to reach from the ports is a register write that lands while a cycle is running. It has to arrive after the go has been accepted and before the done flag appears. The stimulus starts a 64-byte read, which takes several thousand clocks. Within that read it writes a new go, a new address and a buffer word. After the read completes, it checks that only one frame was sent, that the address and fields were kept, and that the buffer holds the flash data rather than the software word. A simple flash model on the pins logs every MOSI byte per frame and returns a known byte sequence, so opcode, address order, dummy placement and data placement are all checked byte for byte.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;

  localparam int unsigned BUF_BYTES = 64;
  localparam int unsigned BUF_IW    = $clog2(BUF_BYTES);

  typedef enum logic [2:0] {
    S_IDLE, S_WEN, S_GAP, S_OP, S_ADR, S_DMY, S_DAT, S_END
  } seq_state_e;

  localparam logic [3:0] CYC_READ  = 4'd0;
  localparam logic [3:0] CYC_PROG  = 4'd2;
  localparam logic [3:0] CYC_ER4K  = 4'd3;
  localparam logic [3:0] CYC_ER64K = 4'd4;
  localparam logic [3:0] CYC_SFDP  = 4'd5;
  localparam logic [3:0] CYC_RDID  = 4'd6;
  localparam logic [3:0] CYC_WRSR  = 4'd7;
  localparam logic [3:0] CYC_RDSR  = 4'd8;

  function automatic logic cyc_valid(logic [3:0] c);
    return (c == CYC_READ) || (c >= CYC_PROG && c <= CYC_RDSR);
  endfunction

  function automatic logic cyc_wren(logic [3:0] c);
    return (c == CYC_PROG) || (c == CYC_ER4K) || (c == CYC_ER64K) || (c == CYC_WRSR);
  endfunction

  function automatic logic cyc_addr(logic [3:0] c);
    return (c == CYC_READ) || (c == CYC_SFDP) || (c == CYC_PROG) ||
           (c == CYC_ER4K) || (c == CYC_ER64K);
  endfunction

  function automatic logic cyc_dummy(logic [3:0] c);
    return (c == CYC_READ) || (c == CYC_SFDP);
  endfunction

  function automatic logic cyc_rd(logic [3:0] c);
    return (c == CYC_READ) || (c == CYC_SFDP) || (c == CYC_RDID) || (c == CYC_RDSR);
  endfunction

  function automatic logic cyc_wr(logic [3:0] c);
    return (c == CYC_PROG) || (c == CYC_WRSR);
  endfunction

  function automatic logic [7:0] cyc_opcode(logic [3:0] c);
    case (c)
      CYC_READ:  return 8'h0B;
      CYC_PROG:  return 8'h02;
      CYC_ER4K:  return 8'h20;
      CYC_ER64K: return 8'hD8;
      CYC_SFDP:  return 8'h5A;
      CYC_RDID:  return 8'h9F;
      CYC_WRSR:  return 8'h01;
      CYC_RDSR:  return 8'h05;
      default:   return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int unsigned CW = $clog2(CLK_DIV + 1);

  logic          busy_q, sck_q, done_q;
  logic [CW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        tx_q   <= tx_i;
        div_q  <= '0;
        bit_q  <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q) begin
        if (div_q == CW'(CLK_DIV - 1)) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};  // sample on rising edge
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};  // shift on falling edge
            end
          end
        end else begin
          div_q <= div_q + CW'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];

  a_r13_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  a_r13_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> busy_q || done_q);

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_eng_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        cyc_i,
  input  logic [23:0]       addr_i,
  input  logic [5:0]        cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BUF_IW-1:0] buf_idx_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              sh_start_o,
  output logic [7:0]        sh_tx_o,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              csn_o
);
  localparam int unsigned GAP_CYC = 2 * CLK_DIV;
  localparam int unsigned GW      = $clog2(GAP_CYC + 1);

  seq_state_e  state_q;
  logic [5:0]  byte_q;
  logic        inflight_q;
  logic [GW-1:0] gap_q;
  logic        in_frame, has_data;

  assign has_data = cyc_rd(cyc_i) || cyc_wr(cyc_i);
  assign in_frame = (state_q == S_WEN) || (state_q == S_OP) || (state_q == S_ADR) ||
                    (state_q == S_DMY) || (state_q == S_DAT);
  assign sh_start_o = in_frame && !inflight_q;

  always_comb begin
    unique case (state_q)
      S_WEN:   sh_tx_o = 8'h06;
      S_OP:    sh_tx_o = cyc_opcode(cyc_i);
      S_ADR:   sh_tx_o = (byte_q[1:0] == 2'd0) ? addr_i[23:16] :
                         (byte_q[1:0] == 2'd1) ? addr_i[15:8] : addr_i[7:0];
      S_DAT:   sh_tx_o = cyc_wr(cyc_i) ? buf_rdata_i : 8'h00;
      default: sh_tx_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      byte_q     <= '0;
      inflight_q <= 1'b0;
      gap_q      <= '0;
    end else begin
      if (sh_start_o) inflight_q <= 1'b1;
      if (sh_done_i)  inflight_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= cyc_wren(cyc_i) ? S_WEN : S_OP;
          byte_q  <= '0;
        end
        S_WEN: if (sh_done_i) begin
          state_q <= S_GAP;
          gap_q   <= '0;
        end
        S_GAP: begin
          if (gap_q == GW'(GAP_CYC - 1)) state_q <= S_OP;
          else gap_q <= gap_q + GW'(1);
        end
        S_OP: if (sh_done_i) begin
          byte_q  <= '0;
          state_q <= cyc_addr(cyc_i) ? S_ADR : (has_data ? S_DAT : S_END);
        end
        S_ADR: if (sh_done_i) begin
          if (byte_q == 6'd2) begin
            byte_q  <= '0;
            state_q <= cyc_dummy(cyc_i) ? S_DMY : (has_data ? S_DAT : S_END);
          end else begin
            byte_q <= byte_q + 6'd1;
          end
        end
        S_DMY: if (sh_done_i) begin
          byte_q  <= '0;
          state_q <= S_DAT;
        end
        S_DAT: if (sh_done_i) begin
          if (byte_q == cnt_i) state_q <= S_END;
          else byte_q <= byte_q + 6'd1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != S_IDLE;
  assign done_o      = state_q == S_END;
  assign csn_o       = !in_frame;
  assign buf_idx_o   = BUF_IW'(byte_q);
  assign buf_we_o    = (state_q == S_DAT) && sh_done_i && cyc_rd(cyc_i);
  assign buf_wdata_o = sh_rx_i;

  a_r6_buf_wr_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> !csn_o);
  a_r12_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> state_q == S_IDLE);
  a_r4_gap_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WEN && sh_done_i) |=> csn_o);

endmodule

// File: rtl/flash_cycle_engine.sv
module flash_cycle_engine
  import flash_eng_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 2,
  parameter logic [23:0] ADDR_MAX = 24'h3F_FFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sck_o,
  output logic        csn_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  logic [23:0] addr_q;
  logic [3:0]  cyc_q;
  logic [5:0]  cnt_q;
  logic [2:0]  flags_q, flags_d;
  logic        start_q;
  logic [7:0]  buf_q [BUF_BYTES];

  logic seq_busy, seq_done, busy;
  logic [BUF_IW-1:0] seq_idx;
  logic seq_we;
  logic [7:0] seq_wdata;
  logic sh_start, sh_done, sh_busy;
  logic [7:0] sh_tx, sh_rx;

  logic wr_ctrl, wr_addr, wr_buf, go_req, bad_acc, page_x;
  logic [3:0] new_cyc;
  logic [5:0] new_cnt;

  assign busy    = seq_busy || start_q;
  assign wr_ctrl = reg_we_i && reg_addr_i == 5'd1;
  assign wr_addr = reg_we_i && reg_addr_i == 5'd0 && !busy;
  assign wr_buf  = reg_we_i && reg_addr_i[4] && !busy;
  assign new_cyc = reg_wdata_i[20:17];
  assign new_cnt = reg_wdata_i[29:24];
  assign go_req  = wr_ctrl && reg_wdata_i[16] && !busy;
  assign bad_acc = !cyc_valid(new_cyc) || (addr_q > ADDR_MAX);
  assign page_x  = (new_cyc == CYC_PROG) &&
                   (({1'b0, addr_q[7:0]} + {3'b000, new_cnt}) > 9'd255);

  always_comb begin
    flags_d = flags_q & ~(wr_ctrl ? reg_wdata_i[2:0] : 3'b000);
    if (seq_done) flags_d[0] = 1'b1;
    if (go_req && bad_acc)      flags_d[2] = 1'b1;
    else if (go_req && page_x)  flags_d[1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      cyc_q   <= '0;
      cnt_q   <= '0;
      flags_q <= '0;
      start_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      start_q <= go_req && !bad_acc && !page_x;
      if (wr_addr) addr_q <= reg_wdata_i[23:0];
      if (wr_ctrl && !busy) begin
        cyc_q <= new_cyc;
        cnt_q <= new_cnt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
    end else if (seq_we) begin
      buf_q[seq_idx] <= seq_wdata;
    end else if (wr_buf) begin
      for (int j = 0; j < 4; j++)
        buf_q[{reg_addr_i[3:0], 2'(j)}] <= reg_wdata_i[8*j +: 8];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[4]) begin
      for (int j = 0; j < 4; j++)
        reg_rdata_o[8*j +: 8] = buf_q[{reg_addr_i[3:0], 2'(j)}];
    end else if (reg_addr_i == 5'd0) begin
      reg_rdata_o = {8'h00, addr_q};
    end else if (reg_addr_i == 5'd1) begin
      reg_rdata_o = {2'b00, cnt_q, 3'b000, cyc_q, 1'b0, 10'd0, busy, 2'b00, flags_q};
    end
  end

  flash_seq #(.CLK_DIV(CLK_DIV)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_q),
    .cyc_i       (cyc_q),
    .addr_i      (addr_q),
    .cnt_i       (cnt_q),
    .busy_o      (seq_busy),
    .done_o      (seq_done),
    .buf_idx_o   (seq_idx),
    .buf_we_o    (seq_we),
    .buf_wdata_o (seq_wdata),
    .buf_rdata_i (buf_q[seq_idx]),
    .sh_start_o  (sh_start),
    .sh_tx_o     (sh_tx),
    .sh_done_i   (sh_done),
    .sh_rx_i     (sh_rx),
    .csn_o       (csn_o)
  );

  spi_byte_shifter #(.CLK_DIV(CLK_DIV)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .tx_i    (sh_tx),
    .miso_i  (miso_i),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o)
  );

  a_r9_start_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> cyc_valid(cyc_q) && addr_q <= ADDR_MAX);
  a_r8_done_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done |=> flags_q[0]);
  a_r12_fields_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy |=> $stable(addr_q) && $stable(cyc_q) && $stable(cnt_q));
  a_r13_shift_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_busy |-> !csn_o);

endmodule

// File: tb/test_flash_cycle_engine.sv
module test_flash_cycle_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] ra = '0;
  logic [31:0] wd = '0, rd;
  logic sck, csn, mosi, miso;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cycle_engine i_flash_cycle_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .sck_o(sck), .csn_o(csn),
    .mosi_o(mosi), .miso_i(miso));

  // flash model: logs MOSI bytes, returns resp(k) for the k-th byte of a frame
  int bit_cnt = 0, log_n = 0, frames = 0, frame_start = 0;
  logic [7:0] sh_in = '0;
  logic [7:0] log_b [128];

  function automatic logic [7:0] resp(int k);
    return 8'(8'h3C + 7 * k);
  endfunction

  function automatic logic resp_bit(int c);
    logic [7:0] b = resp(c / 8);
    return b[7 - (c % 8)];
  endfunction

  assign miso = resp_bit(bit_cnt);

  always @(negedge csn) begin
    bit_cnt = 0;
    frame_start = log_n;
  end
  always @(posedge csn) if (rst_n) frames++;
  always @(posedge sck) if (!csn) begin
    sh_in = {sh_in[6:0], mosi};
    bit_cnt++;
    if (bit_cnt % 8 == 0 && log_n < 128) begin
      log_b[log_n] = sh_in;
      log_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; ra = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    ra = a;
    #1 d = rd;
  endtask

  function automatic logic [31:0] ctrl_word(logic [3:0] c, logic [5:0] n, bit go, logic [7:0] w1c);
    return {2'b00, n, 3'b000, c, go, 8'h00, w1c};
  endfunction

  task automatic clear_log();
    log_n = 0; frames = 0; frame_start = 0;
  endtask

  task automatic wait_end(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 20000; i++) begin
      reg_read(5'd1, st);
      if (st[2:0] != 3'b000) break;
    end
  endtask

  task automatic run_cycle(input logic [3:0] c, input logic [23:0] a,
                           input logic [5:0] n, output logic [31:0] st);
    reg_write(5'd1, ctrl_word(4'd0, 6'd0, 1'b0, 8'hFF));
    reg_write(5'd0, {8'h00, a});
    clear_log();
    reg_write(5'd1, ctrl_word(c, n, 1'b1, 8'h00));
    wait_end(st);
    repeat (4) @(negedge clk);
  endtask

  // {cycle, address, count-1, opcode, frames, total bytes, flags}
  localparam int NV = 13;
  localparam logic [56:0] VEC [NV] = '{
    {4'd0, 24'h000100, 6'd3,  8'h0B, 4'd1, 8'd9,  3'b001},
    {4'd2, 24'h000010, 6'd7,  8'h02, 4'd2, 8'd13, 3'b001},
    {4'd3, 24'h001000, 6'd0,  8'h20, 4'd2, 8'd5,  3'b001},
    {4'd4, 24'h010000, 6'd0,  8'hD8, 4'd2, 8'd5,  3'b001},
    {4'd5, 24'h000000, 6'd1,  8'h5A, 4'd1, 8'd7,  3'b001},
    {4'd6, 24'h000000, 6'd2,  8'h9F, 4'd1, 8'd4,  3'b001},
    {4'd7, 24'h000000, 6'd0,  8'h01, 4'd2, 8'd3,  3'b001},
    {4'd8, 24'h000000, 6'd0,  8'h05, 4'd1, 8'd2,  3'b001},
    {4'd1, 24'h000000, 6'd0,  8'h00, 4'd0, 8'd0,  3'b100},
    {4'd9, 24'h000000, 6'd0,  8'h00, 4'd0, 8'd0,  3'b100},
    {4'd0, 24'h400000, 6'd0,  8'h00, 4'd0, 8'd0,  3'b100},
    {4'd2, 24'h0000F8, 6'd15, 8'h00, 4'd0, 8'd0,  3'b010},
    {4'd2, 24'h0000C0, 6'd63, 8'h02, 4'd2, 8'd69, 3'b001}
  };

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] st, v;
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_read(5'd0, v);
    check(v == 32'h0, "R1 addr reg", v, 0);
    reg_read(5'd1, v);
    check(v == 32'h0, "R1 ctrl reg", v, 0);
    check(csn === 1'b1 && sck === 1'b0, "R1 pins", {csn, sck}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R9 R10 table walk
    for (int k = 0; k < NV; k++) begin
      logic [56:0] e = VEC[k];
      run_cycle(e[56:53], e[52:29], e[28:23], st);
      check(st[2:0] == e[2:0], "R3/R9/R10 flags", st[2:0], e[2:0]);
      check(frames == int'(e[14:11]), "R4 frame count", frames, e[14:11]);
      check(log_n == int'(e[10:3]), "R5 byte count", log_n, e[10:3]);
      if (e[14:11] != 0)
        check(log_b[frame_start] == e[22:15], "R3 opcode", log_b[frame_start], e[22:15]);
      if (e[14:11] == 2)
        check(log_b[0] == 8'h06, "R4 write enable", log_b[0], 8'h06);
    end

    // R6 R13 read data lands in buffer
    run_cycle(4'd0, 24'h000200, 6'd5, st);
    check(log_b[1] == 8'h00 && log_b[2] == 8'h02 && log_b[3] == 8'h00,
          "R5 address order", {log_b[1], log_b[2], log_b[3]}, 24'h000200);
    reg_read(5'd16, v);
    check(v == {resp(8), resp(7), resp(6), resp(5)}, "R6 R13 read word0", v,
          {resp(8), resp(7), resp(6), resp(5)});
    reg_read(5'd17, v);
    check(v[15:0] == {resp(10), resp(9)}, "R6 read word1", v[15:0], {resp(10), resp(9)});

    // R6 read ID, no header beyond opcode
    run_cycle(4'd6, 24'h0, 6'd2, st);
    reg_read(5'd16, v);
    check(v[23:0] == {resp(3), resp(2), resp(1)}, "R6 read id", v[23:0],
          {resp(3), resp(2), resp(1)});

    // R7 R2 program data from buffer
    for (int w = 0; w < 3; w++)
      reg_write(5'(16 + w), {8'(8'h93 + 4*w), 8'(8'h92 + 4*w), 8'(8'h91 + 4*w), 8'(8'h90 + 4*w)});
    run_cycle(4'd2, 24'h000020, 6'd9, st);
    check(log_n == 15, "R7 bytes", log_n, 15);
    for (int i = 0; i < 10; i++)
      check(log_b[5 + i] == 8'(8'h90 + i), "R7 data byte", log_b[5 + i], 8'(8'h90 + i));
    check(log_b[4] == 8'h20, "R5 addr low byte", log_b[4], 8'h20);

    // R11 write-1-to-clear selectivity
    reg_write(5'd1, ctrl_word(4'd0, 6'd0, 1'b0, 8'h02));
    reg_read(5'd1, v);
    check(v[0] == 1'b1, "R11 done kept", v[0], 1);
    reg_write(5'd1, ctrl_word(4'd0, 6'd0, 1'b0, 8'h01));
    reg_read(5'd1, v);
    check(v[2:0] == 3'b000, "R11 done cleared", v[2:0], 0);

    // R8 R12 in-progress and ignored writes
    reg_write(5'd0, 24'h000300);
    clear_log();
    reg_write(5'd1, ctrl_word(4'd0, 6'd63, 1'b1, 8'h00));
    reg_read(5'd1, v);
    check(v[5] == 1'b1, "R8 in progress", v[5], 1);
    reg_write(5'd0, 32'h0000_0055);
    reg_write(5'd1, ctrl_word(4'd3, 6'd0, 1'b1, 8'h00));
    reg_write(5'd16, 32'hDEAD_BEEF);
    wait_end(st);
    repeat (4) @(negedge clk);
    check(st[2:0] == 3'b001, "R8 done", st[2:0], 1);
    check(frames == 1, "R12 go ignored", frames, 1);
    reg_read(5'd1, v);
    check(v[5] == 1'b0 && v[20:17] == 4'd0 && v[29:24] == 6'd63, "R12 fields kept",
          v, ctrl_word(4'd0, 6'd63, 1'b0, 8'h01));
    reg_read(5'd0, v);
    check(v == 32'h300, "R12 address kept", v, 32'h300);
    reg_read(5'd16, v);
    check(v == {resp(8), resp(7), resp(6), resp(5)}, "R12 buffer kept", v,
          {resp(8), resp(7), resp(6), resp(5)});
    reg_read(5'd31, v);
    check(v[31:24] == resp(68), "R6 last byte", v[31:24], resp(68));
    check(sck === 1'b0 && csn === 1'b1, "R13 idle pins", {csn, sck}, 2'b10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule